// File: doc/BRIEF.md
# Debug Trace Message Packetizer

The block accepts one debug trace message at a time and sends it out over a narrow lane, a few bits per clock. A second, 2-bit framing output runs beside the lane and marks on every clock whether a message starts or continues, whether a packet ends, or whether the message ends. Each message has two segments. The header segment holds the 6-bit type code, the 4-bit source ID, the 3-bit data-size code and a variable-length address portion. The data segment is the write data, 8, 16 or 32 bits wide. Each field is packed least-significant bit first. The fixed fields and the address run back to back across clock boundaries. The data always starts at lane bit 0 on the clock after the header ends.

A producer presents the message fields together with a valid flag. The block raises ready only when it is idle, or on the clock that ends the current message. A new message can therefore follow the previous one with no idle clock between them. The unused lane bits on the last clock of a segment are driven to zero. Address bits above the requested length and data bits above the selected size never reach the lane.

Top module: `trace_packetizer`

## Requirements
- R1: While no message is in flight, including straight after reset, `mseo` is 2'b11, `mdo` is all zeros and `msg_ready` is 1.
- R2: The first clock of a message, one clock after it is accepted, drives `mseo` = 2'b00. With a 12-bit lane, `mdo[5:0]` carries the type code, `mdo[9:6]` the source ID and `mdo[11:10]` data-size bits 1:0.
- R3: The header segment is the bit string {address masked to its length, data-size code, source ID, type code}, with the type code lowest. It is sent in 12-bit slices from the lowest bit upward, one slice per clock, over ceil((13 + address length)/12) clocks.
- R4: Every clock of the header segment drives `mseo` = 2'b00, except its last clock, which drives 2'b01.
- R5: The data segment starts at `mdo[0]` on the clock after the 2'b01 clock. Its width follows the data-size code: 0 selects 8 bits, 1 selects 16 bits, and any other code selects 32 bits. It takes ceil(width/12) clocks. Its last clock drives `mseo` = 2'b11 and every other clock drives 2'b00.
- R6: On the last clock of each segment, every `mdo` bit above the segment's remaining bits is zero. Address bits at or above the address length, and write-data bits at or above the selected width, are sent as zero.
- R7: `msg_ready` is 1 only when idle or on the last clock of the data segment. Any `msg_valid` and field values presented while `msg_ready` is 0 have no effect on the outputs.
- R8: A message accepted on the end-of-message clock starts on the very next clock with `mseo` = 2'b00, with no idle clock in between.
- R9: An address length request larger than `ADDR_W` is treated as `ADDR_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_valid | input | 1 | A message is presented |
| msg_ready | output | 1 | The presented message is taken at this clock edge |
| msg_tcode | input | 6 | Message type code |
| msg_src | input | 4 | Source ID |
| msg_dsize | input | 3 | Data-size code (0: 8, 1: 16, else 32 bits) |
| msg_addr | input | ADDR_W | Address portion |
| msg_alen | input | $clog2(ADDR_W+1) | Number of address bits to send |
| msg_wdata | input | 32 | Write data |
| mdo | output | LANE_W | Message data lane |
| mseo | output | 2 | Framing code: 00 start/continue, 01 packet end, 11 message end or idle |

## Verification
The bench builds the block with `ADDR_W` = 16 and the default 12-bit lane. A 16-bit address pushes the header to three clocks, so it reaches both the single-intermediate-clock and the two-clock header shapes. The 5-bit length input can request lengths 17 to 31, which exercises the clamp. The sweep covers every address length from 0 to 31 against every 3-bit data-size code, alternating gapped and back-to-back starts. Junk fields are presented while the block is busy.

// File: rtl/trace_pkt_pkg.sv
package trace_pkt_pkg;

  localparam int unsigned TC_W     = 6;
  localparam int unsigned SRC_W    = 4;
  localparam int unsigned DSZ_W    = 3;
  localparam int unsigned FIX_W    = TC_W + SRC_W + DSZ_W;
  localparam int unsigned DATA_MAX = 32;

  // framing codes on the start/end output
  localparam logic [1:0] MSEO_GO      = 2'b00;
  localparam logic [1:0] MSEO_PKT_END = 2'b01;
  localparam logic [1:0] MSEO_MSG_END = 2'b11;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_DAT  = 2'd2
  } phase_t;

  // width in bits selected by the data-size code
  function automatic int unsigned data_bits(input logic [DSZ_W-1:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 16;
      default: return 32;
    endcase
  endfunction

  // requested length limited to the available field width
  function automatic int unsigned clamp_len(input int unsigned req,
                                            input int unsigned cap);
    return (req > cap) ? cap : req;
  endfunction

endpackage

// File: rtl/trace_seg_builder.sv
module trace_seg_builder
  import trace_pkt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ALEN_W = 6,
  parameter int unsigned SH_W   = 45,
  parameter int unsigned LEN_W  = 6
) (
  input  logic [TC_W-1:0]     tcode,
  input  logic [SRC_W-1:0]    src,
  input  logic [DSZ_W-1:0]    dsize,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [ALEN_W-1:0]   alen,
  input  logic [DATA_MAX-1:0] wdata,
  output logic [SH_W-1:0]     hdr_vec,
  output logic [LEN_W-1:0]    hdr_len,
  output logic [SH_W-1:0]     dat_vec,
  output logic [LEN_W-1:0]    dat_len
);

  int unsigned         alen_req;
  int unsigned         alen_eff;
  int unsigned         dbits;
  logic [ADDR_W-1:0]   addr_m;
  logic [DATA_MAX-1:0] data_m;

  always_comb begin
    alen_req = 32'(alen);
    alen_eff = clamp_len(alen_req, ADDR_W);
    dbits    = data_bits(dsize);
    for (int unsigned i = 0; i < ADDR_W; i++) begin
      addr_m[i] = addr[i] & (i < alen_eff);
    end
    for (int unsigned i = 0; i < DATA_MAX; i++) begin
      data_m[i] = wdata[i] & (i < dbits);
    end
    hdr_vec = SH_W'({addr_m, dsize, src, tcode});
    hdr_len = LEN_W'(FIX_W + alen_eff);
    dat_vec = SH_W'(data_m);
    dat_len = LEN_W'(dbits);
  end

endmodule

// File: rtl/trace_beat_shifter.sv
module trace_beat_shifter #(
  parameter int unsigned SH_W   = 45,
  parameter int unsigned LEN_W  = 6,
  parameter int unsigned LANE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [SH_W-1:0]   vec,
  input  logic [LEN_W-1:0]  len,
  output logic [LANE_W-1:0] lane,
  output logic              seg_last
);

  localparam logic [LEN_W-1:0] LANE_LEN = LEN_W'(LANE_W);

  logic [SH_W-1:0]  sh_q;
  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rem_q <= '0;
    end else if (load) begin
      sh_q  <= vec;
      rem_q <= len;
    end else if (step) begin
      sh_q  <= sh_q >> LANE_W;
      rem_q <= (rem_q > LANE_LEN) ? rem_q - LANE_LEN : '0;
    end
  end

  assign lane     = sh_q[LANE_W-1:0];
  assign seg_last = (rem_q != '0) && (rem_q <= LANE_LEN);

  AST_LAST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    seg_last |-> ((sh_q >> rem_q) == '0)); // R6

  AST_STEP_HAS_MORE: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (rem_q > LANE_LEN)); // R3

endmodule

// File: rtl/trace_frame_ctrl.sv
module trace_frame_ctrl
  import trace_pkt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       seg_last,
  output logic       in_ready,
  output logic       ld_hdr,
  output logic       ld_dat,
  output logic       step,
  output logic       busy,
  output logic [1:0] mseo
);

  phase_t ph_q, ph_d;
  logic   accept;

  always_comb begin
    in_ready = (ph_q == PH_IDLE) || ((ph_q == PH_DAT) && seg_last);
    accept   = in_valid && in_ready;
    ld_hdr   = accept;
    ld_dat   = (ph_q == PH_HDR) && seg_last;
    step     = (ph_q != PH_IDLE) && !seg_last;
    busy     = (ph_q != PH_IDLE);
    ph_d     = ph_q;
    mseo     = MSEO_MSG_END;
    case (ph_q)
      PH_IDLE: begin
        if (accept) ph_d = PH_HDR;
      end
      PH_HDR: begin
        mseo = seg_last ? MSEO_PKT_END : MSEO_GO;
        if (seg_last) ph_d = PH_DAT;
      end
      PH_DAT: begin
        mseo = seg_last ? MSEO_MSG_END : MSEO_GO;
        if (seg_last) ph_d = accept ? PH_HDR : PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  AST_READY_AT_END_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (mseo == MSEO_MSG_END)); // R7

  AST_ACCEPT_OPENS_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mseo != MSEO_MSG_END) && (ph_q == PH_HDR)); // R2

  AST_PKT_END_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (mseo == MSEO_PKT_END) |=> (mseo != MSEO_PKT_END) && (ph_q == PH_DAT)); // R5

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_DAT) && seg_last && in_valid) |=> (ph_q == PH_HDR)); // R8

endmodule

// File: rtl/trace_packetizer.sv
module trace_packetizer
  import trace_pkt_pkg::*;
#(
  parameter  int unsigned ADDR_W = 32,
  parameter  int unsigned LANE_W = 12,
  localparam int unsigned ALEN_W = $clog2(ADDR_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                msg_valid,
  output logic                msg_ready,
  input  logic [TC_W-1:0]     msg_tcode,
  input  logic [SRC_W-1:0]    msg_src,
  input  logic [DSZ_W-1:0]    msg_dsize,
  input  logic [ADDR_W-1:0]   msg_addr,
  input  logic [ALEN_W-1:0]   msg_alen,
  input  logic [DATA_MAX-1:0] msg_wdata,
  output logic [LANE_W-1:0]   mdo,
  output logic [1:0]          mseo
);

  localparam int unsigned SH_W  = (FIX_W + ADDR_W > DATA_MAX) ? FIX_W + ADDR_W : DATA_MAX;
  localparam int unsigned LEN_W = $clog2(SH_W + 1);

  logic [SH_W-1:0]   hdr_vec, dat_vec, dat_vec_q, sh_vec;
  logic [LEN_W-1:0]  hdr_len, dat_len, dat_len_q, sh_len;
  logic [LANE_W-1:0] lane;
  logic              seg_last, ld_hdr, ld_dat, step, busy;

  trace_seg_builder #(
    .ADDR_W(ADDR_W), .ALEN_W(ALEN_W), .SH_W(SH_W), .LEN_W(LEN_W)
  ) u_build (
    .tcode(msg_tcode), .src(msg_src), .dsize(msg_dsize), .addr(msg_addr),
    .alen(msg_alen), .wdata(msg_wdata),
    .hdr_vec(hdr_vec), .hdr_len(hdr_len), .dat_vec(dat_vec), .dat_len(dat_len)
  );

  trace_frame_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(msg_valid), .seg_last(seg_last),
    .in_ready(msg_ready), .ld_hdr(ld_hdr), .ld_dat(ld_dat), .step(step),
    .busy(busy), .mseo(mseo)
  );

  // data segment waits here while the header is on the lane
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_vec_q <= '0;
      dat_len_q <= '0;
    end else if (ld_hdr) begin
      dat_vec_q <= dat_vec;
      dat_len_q <= dat_len;
    end
  end

  assign sh_vec = ld_hdr ? hdr_vec : dat_vec_q;
  assign sh_len = ld_hdr ? hdr_len : dat_len_q;

  trace_beat_shifter #(
    .SH_W(SH_W), .LEN_W(LEN_W), .LANE_W(LANE_W)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .load(ld_hdr | ld_dat), .step(step),
    .vec(sh_vec), .len(sh_len), .lane(lane), .seg_last(seg_last)
  );

  assign mdo = busy ? lane : '0;

  AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mdo == '0) && msg_ready); // R1

  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hdr && ld_dat)); // R8

endmodule

// File: tb/test_trace_packetizer.sv
`timescale 1ns/1ps
module test_trace_packetizer;

  localparam int unsigned AW = 16;
  localparam int unsigned LW = $clog2(AW + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          msg_valid;
  logic          msg_ready;
  logic [5:0]    msg_tcode;
  logic [3:0]    msg_src;
  logic [2:0]    msg_dsize;
  logic [AW-1:0] msg_addr;
  logic [LW-1:0] msg_alen;
  logic [31:0]   msg_wdata;
  logic [11:0]   mdo;
  logic [1:0]    mseo;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  trace_packetizer #(.ADDR_W(AW), .LANE_W(12)) i_trace_packetizer (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_tcode(msg_tcode), .msg_src(msg_src), .msg_dsize(msg_dsize),
    .msg_addr(msg_addr), .msg_alen(msg_alen), .msg_wdata(msg_wdata),
    .mdo(mdo), .mseo(mseo)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_width(input int dz);
    if (dz == 0) return 8;
    if (dz == 1) return 16;
    return 32;
  endfunction

  task automatic check_idle();
    chk("R1 mseo idle", 64'(mseo), 64'(2'b11));
    chk("R1 mdo idle", 64'(mdo), 64'd0);
    chk("R1 ready idle", 64'(msg_ready), 64'd1);
  endtask

  // called at a negedge where the block must be ready; returns at the
  // negedge of the message's end clock
  task automatic send(input int tc, input int sr, input int dz, input int al,
                      input logic [AW-1:0] ad, input logic [31:0] wd,
                      input string first_tag);
    logic [63:0] hseq, dseq, exp_mdo;
    int ale, hlen, dlen, hb, db, tot;
    string tag;
    msg_valid = 1'b1;
    msg_tcode = 6'(tc);
    msg_src   = 4'(sr);
    msg_dsize = 3'(dz);
    msg_addr  = ad;
    msg_alen  = LW'(al);
    msg_wdata = wd;
    chk("R7 ready before accept", 64'(msg_ready), 64'd1);
    ale  = (al > int'(AW)) ? int'(AW) : al;
    hseq = 64'(tc) | (64'(sr) << 6) | (64'(dz) << 10) |
           ((64'(ad) & ((64'd1 << ale) - 64'd1)) << 13);
    hlen = 13 + ale;
    dlen = exp_width(dz);
    dseq = 64'(wd) & ((64'd1 << dlen) - 64'd1);
    hb   = (hlen + 11) / 12;
    db   = (dlen + 11) / 12;
    tot  = hb + db;
    @(negedge clk);
    for (int k = 0; k < tot; k++) begin
      if (k < hb) begin
        exp_mdo = (hseq >> (12 * k)) & 64'hFFF;
        tag = (k == 0) ? first_tag : ((k == hb - 1) ? "R6" : "R3");
        if (al > int'(AW)) tag = {tag, "/R9"};
        chk($sformatf("%s header beat %0d", tag, k), 64'(mdo), exp_mdo);
        chk($sformatf("R4 header mseo beat %0d", k), 64'(mseo),
            (k == hb - 1) ? 64'(2'b01) : 64'(2'b00));
      end else begin
        exp_mdo = (dseq >> (12 * (k - hb))) & 64'hFFF;
        tag = (k == tot - 1) ? "R6" : "R5";
        chk($sformatf("%s data beat %0d dsize %0d", tag, k - hb, dz), 64'(mdo), exp_mdo);
        chk($sformatf("R5 data mseo beat %0d", k - hb), 64'(mseo),
            (k == tot - 1) ? 64'(2'b11) : 64'(2'b00));
      end
      chk($sformatf("R7 ready beat %0d", k), 64'(msg_ready), (k == tot - 1) ? 64'd1 : 64'd0);
      if (k != tot - 1) begin
        // junk presented while busy must be ignored
        msg_valid = 1'b1;
        msg_tcode = ~6'(tc);
        msg_src   = ~4'(sr);
        msg_dsize = 3'(dz + 3);
        msg_addr  = ~ad;
        msg_alen  = LW'(al + 5);
        msg_wdata = ~wd;
        @(negedge clk);
      end else begin
        msg_valid = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    msg_valid = 1'b0;
    msg_tcode = '0;
    msg_src   = '0;
    msg_dsize = '0;
    msg_addr  = '0;
    msg_alen  = '0;
    msg_wdata = '0;
    repeat (3) @(negedge clk);
    check_idle();
    rst_n = 1'b1;
    @(negedge clk);
    check_idle();

    for (int al = 0; al < 32; al++) begin
      for (int dz = 0; dz < 8; dz++) begin
        logic b2b;
        b2b = ((al + dz) % 3) != 0;
        send((al * 7 + dz * 5 + 1) & 63, (al + 3 * dz) & 15, dz, al,
             AW'(16'hA5C3 ^ 16'(al * 4099)), 32'hDEADBEEF ^ 32'(al * 65793 + dz * 16777619),
             b2b ? "R8" : "R2");
        if (!b2b) begin
          @(negedge clk);
          check_idle();
        end
      end
    end
    @(negedge clk);
    check_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule